// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Output Coding

This block runs one 8-bit successive-approximation conversion each time it is started and delivers the finished code in the format that the selected input mode calls for. A start pulse first opens an acquisition (track) window of fixed length. The block then makes eight binary-search decisions, one per clock. On each decision it presents a trial code to an external comparator and reads back one bit that says whether the held input is at or above that trial.

The output format depends on two mode inputs, which are captured at start. A single-ended input always gives straight binary from zero to full scale, whatever the polarity select says. A pseudo-differential input with unipolar coding also gives straight binary, and a negative difference yields code zero. A pseudo-differential input with bipolar coding gives two's complement over plus or minus half of full scale. While that mode is active the block raises a flag, so the comparator shifts its reference by half scale. An opaque channel tag is captured at start and returned with the result.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After acquisition the block spends exactly 8 consecutive cycles converting, with busy_o high and track_o low, and resolves one trial bit per cycle.
- R2: An accepted start is followed by exactly ACQ_CYCLES (default 2) cycles with track_o and busy_o high before the first conversion cycle. In that first conversion cycle trial_o is 8'h80.
- R3: When single_ended_i is 1 at start, bip_mode_o stays 0 and the result is straight binary, whatever the value of bipolar_i.
- R4: In unipolar mode the result is straight binary: the input value clamped to 0..255.
- R5: In unipolar mode a negative difference gives result 8'h00.
- R6: When single_ended_i is 0 and bipolar_i is 1 at start, bip_mode_o is 1 and the result is the difference in two's complement over -128..127. The result saturates at 8'h80 and 8'h7F. The comparator must then treat trial_o as offset binary, with the difference plus 128 compared against the trial.
- R7: done_o is high for exactly one cycle per conversion, in the cycle after the last decision. result_o and tag_o hold their values until the next done_o.
- R8: A start pulse while busy_o is high is ignored: the running conversion keeps its length, its modes, its tag and its result.
- R9: tag_o returns the tag_i value captured when the conversion was accepted.
- R10: After reset, busy_o, track_o, done_o, bip_mode_o, result_o and tag_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| single_ended_i | input | 1 | 1 = single-ended, 0 = pseudo-differential |
| bipolar_i | input | 1 | 1 = bipolar coding (pseudo-differential only) |
| tag_i | input | TAG_W | Channel tag captured at start |
| cmp_i | input | 1 | Comparator: 1 = held input at or above trial |
| busy_o | output | 1 | Acquisition or conversion in progress |
| track_o | output | 1 | Acquisition window active |
| trial_o | output | W | Trial code to the comparator DAC |
| bip_mode_o | output | 1 | Effective bipolar mode (half-scale offset) |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | W | Coded conversion result |
| tag_o | output | TAG_W | Tag belonging to result_o |

## Verification
The bench covers both ends of each coding range: 0 and full scale in unipolar mode, -128 and +127 in bipolar mode, and inputs beyond those ends, which must saturate. A design that forgot to invert the MSB, or that inverted it in unipolar mode, would be off by 128 at exactly these points. Bipolar requested together with single-ended must still give straight binary; a design that obeyed the polarity select there would return a code shifted by half scale. A start pulse in the middle of a conversion, carrying a different tag and modes, must leave the running conversion unchanged; a design that restarted would lengthen the conversion and return the wrong tag or coding. The bench also counts the acquisition and conversion cycles, so an off-by-one in either counter shows as a wrong count.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int W          = 8,
  parameter int ACQ_CYCLES = 2,
  localparam int IDX_W     = $clog2(W),
  localparam int ACQ_W     = $clog2(ACQ_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output sar_state_e       state_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o,
  output logic             step_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(W - 1);
  localparam logic [ACQ_W-1:0] ACQ_TOP = ACQ_W'(ACQ_CYCLES - 1);

  sar_state_e       state_q, state_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [ACQ_W-1:0] acq_q, acq_n;

  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign step_o  = (state_q == ST_CONV);
  assign last_o  = step_o && (idx_q == '0);
  assign state_o = state_q;
  assign idx_o   = idx_q;

  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    acq_n   = acq_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_n = ST_ACQ;
        acq_n   = ACQ_TOP;
        idx_n   = IDX_TOP;
      end
      ST_ACQ: begin
        if (acq_q == '0) state_n = ST_CONV;
        else             acq_n   = acq_q - 1'b1;
      end
      ST_CONV: begin
        if (idx_q == '0) state_n = ST_IDLE;
        else             idx_n   = idx_q - 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      acq_q   <= '0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      acq_q   <= acq_n;
    end
  end

  // R2: an accepted start always opens acquisition
  a_r2_start_to_acq: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (state_q == ST_ACQ));
  // R1: the final decision returns the sequencer to idle
  a_r1_last_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (state_q == ST_IDLE));
  // R8: a start during acquisition does not end the run
  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACQ) && start_i |=> (state_q != ST_IDLE));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int W      = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             cmp_i,
  output logic [W-1:0]     trial_o,
  output logic [W-1:0]     decided_o
);
  localparam logic [W-1:0] MIDSCALE = W'(1) << (W - 1);

  logic [W-1:0] trial_q, trial_n;

  always_comb begin
    trial_n = trial_q;
    if (load_i) begin
      trial_n = MIDSCALE;
    end else if (step_i) begin
      if (!cmp_i) trial_n[idx_i] = 1'b0;
      if (idx_i != '0) trial_n[idx_i - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 trial_q <= '0;
    else if (load_i || step_i)  trial_q <= trial_n;
  end

  assign trial_o   = trial_q;
  assign decided_o = trial_n;

  // R2: every conversion begins its search at midscale
  a_r2_midscale: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (trial_o == MIDSCALE));
  // R1: a decision never disturbs bits above the one under test
  a_r1_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && (idx_i == IDX_W'(W - 2)) |=> (trial_o[W-1] == $past(trial_o[W-1])));
endmodule

// File: rtl/sar_coder.sv
module sar_coder #(
  parameter int W = 8
) (
  input  logic [W-1:0] code_i,
  input  logic         bipolar_i,
  output logic [W-1:0] coded_o
);
  always_comb begin
    coded_o = code_i;
    if (bipolar_i) coded_o[W-1] = ~code_i[W-1];
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int W          = 8,
  parameter int ACQ_CYCLES = 2,
  parameter int TAG_W      = 4,
  localparam int IDX_W     = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             single_ended_i,
  input  logic             bipolar_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             track_o,
  output logic [W-1:0]     trial_o,
  output logic             bip_mode_o,
  output logic             done_o,
  output logic [W-1:0]     result_o,
  output logic [TAG_W-1:0] tag_o
);
  sar_state_e       state;
  logic [IDX_W-1:0] idx;
  logic             load, step, last;
  logic [W-1:0]     decided, coded;

  logic             bip_q, bip_n;
  logic [TAG_W-1:0] tag_run_q, tag_run_n;
  logic [W-1:0]     res_q, res_n;
  logic [TAG_W-1:0] tag_out_q, tag_out_n;
  logic             done_q;

  sar_sequencer #(.W(W), .ACQ_CYCLES(ACQ_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .state_o(state), .idx_o(idx), .load_o(load), .step_o(step), .last_o(last)
  );

  sar_trial_reg #(.W(W)) u_trial (
    .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step), .idx_i(idx),
    .cmp_i(cmp_i), .trial_o(trial_o), .decided_o(decided)
  );

  sar_coder #(.W(W)) u_coder (
    .code_i(decided), .bipolar_i(bip_q), .coded_o(coded)
  );

  always_comb begin
    bip_n     = bip_q;
    tag_run_n = tag_run_q;
    res_n     = res_q;
    tag_out_n = tag_out_q;
    if (load) begin
      bip_n     = !single_ended_i && bipolar_i;
      tag_run_n = tag_i;
    end
    if (last) begin
      res_n     = coded;
      tag_out_n = tag_run_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bip_q     <= 1'b0;
      tag_run_q <= '0;
      res_q     <= '0;
      tag_out_q <= '0;
      done_q    <= 1'b0;
    end else begin
      if (load) begin
        bip_q     <= bip_n;
        tag_run_q <= tag_run_n;
      end
      if (last) begin
        res_q     <= res_n;
        tag_out_q <= tag_out_n;
      end
      done_q <= last;
    end
  end

  assign busy_o     = (state != ST_IDLE);
  assign track_o    = (state == ST_ACQ);
  assign bip_mode_o = bip_q;
  assign done_o     = done_q;
  assign result_o   = res_q;
  assign tag_o      = tag_out_q;

  // R7: done lasts a single cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7: result and tag move only together with done
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(result_o) && $stable(tag_o)));
  // R1: done follows directly on a conversion cycle
  a_r1_done_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy_o && !track_o));
  // R3: single-ended capture never enables the half-scale offset
  a_r3_se_unipolar: assert property (@(posedge clk) disable iff (!rst_n)
    load && single_ended_i |=> !bip_mode_o);
endmodule

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;
  localparam int W = 8;
  localparam int TAG_W = 4;
  localparam int ACQ = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic se = 1'b0;
  logic bip = 1'b0;
  logic [TAG_W-1:0] tag = '0;
  logic cmp;
  logic busy, track, bip_mode, done;
  logic [W-1:0] trial, result;
  logic [TAG_W-1:0] tag_out;
  int diff = 0;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sar_conv_ctrl #(.W(W), .ACQ_CYCLES(ACQ), .TAG_W(TAG_W)) u_sar_conv_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .single_ended_i(se),
    .bipolar_i(bip), .tag_i(tag), .cmp_i(cmp), .busy_o(busy), .track_o(track),
    .trial_o(trial), .bip_mode_o(bip_mode), .done_o(done), .result_o(result),
    .tag_o(tag_out)
  );

  // behavioural comparator; bipolar mode adds half scale (R6)
  always_comb cmp = ((bip_mode ? diff + 128 : diff) >= int'(trial));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expect_code(input int d, input bit s, input bit b);
    int v;
    if (s || !b) begin
      v = (d < 0) ? 0 : (d > 255 ? 255 : d);
    end else begin
      v = (d < -128) ? -128 : (d > 127 ? 127 : d);
      v = v & 255;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam int NV = 12;
  localparam int VD [NV] = '{0, 255, 100, 173, -40, 300, -1, -128, 127, -200, 55, -5};
  localparam bit VS [NV] = '{1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1};
  localparam bit VB [NV] = '{0, 0, 1, 0, 0, 0, 1, 1, 1, 1, 1, 1};

  // runs one conversion; mid > 0 pulses a second start at that wait cycle
  task automatic run_conv(input int d, input bit s, input bit b, input logic [TAG_W-1:0] t,
                          input int mid);
    int acq_n = 0;
    int conv_n = 0;
    int guard = 0;
    bit first = 1'b1;
    int exp_code = expect_code(d, s, b);
    @(negedge clk);
    diff = d; se = s; bip = b; tag = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 40) begin
      if (track) acq_n++;
      else if (busy) begin
        if (first) chk(trial == 8'h80, "R2 midscale", trial, 128);
        first = 1'b0;
        conv_n++;
      end
      guard++;
      if (guard == mid) begin
        se = ~s; bip = ~b; tag = ~t; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
    end
    chk(done == 1'b1, "R7 done seen", done, 1);
    chk(acq_n == ACQ, "R2 acquisition length", acq_n, ACQ);
    chk(conv_n == 8, "R1 conversion length", conv_n, 8);
    chk(bip_mode == (!s && b), (s ? "R3 mode flag" : "R6 mode flag"), bip_mode, !s && b);
    if (s)       chk(result == exp_code, "R3 single-ended coding", result, exp_code);
    else if (!b) chk(result == exp_code, (d < 0 ? "R5 negative clamp" : "R4 unipolar"), result, exp_code);
    else         chk(result == exp_code, "R6 bipolar coding", result, exp_code);
    chk(tag_out == t, (mid > 0 ? "R8 tag kept" : "R9 tag"), tag_out, t);
    @(negedge clk);
    chk(done == 1'b0, "R7 single pulse", done, 0);
    chk(result == exp_code, "R7 result hold", result, exp_code);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(busy == 0 && track == 0 && done == 0, "R10 reset control", {busy, track, done}, 0);
    chk(result == 0 && tag_out == 0 && bip_mode == 0, "R10 reset data", result, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      run_conv(VD[i], VS[i], VB[i], TAG_W'(i), 0);
    end
    // R8: start pulses during acquisition and during conversion are ignored
    run_conv(-20, 1'b0, 1'b1, 4'h5, 1);
    run_conv(90, 1'b0, 1'b0, 4'hA, 5);
    // R7: result holds across idle cycles with changing inputs
    diff = 7; tag = 4'h3; se = 1'b1;
    repeat (5) @(negedge clk);
    chk(result == 90 && tag_out == 4'hA, "R7 idle hold", result, 90);
    // R4 boundary: one below full scale
    run_conv(254, 1'b0, 1'b0, 4'hF, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule